// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This execution unit treats each 64-bit operand as a group of equal-width lanes and applies one operation to every lane at once. A two-bit size control picks the lane layout at run time. Arithmetic, compare and shift results therefore stay inside lane boundaries, while the bitwise operations ignore the layout and act on the whole word. A signed word multiply-add forms four 16x16 products and sums adjacent pairs into two 32-bit lanes.

Source A always comes from an eight-entry 64-bit register file. Source B comes from the same file or, when selected, from an immediate input port. Raising the valid strobe issues an operation. One clock later the result register holds the answer, a valid pulse goes out, and the result is steered back to the chosen destination register. An operation issued in the cycle the pulse is high already sees the new value through a bypass path, so dependent operations can issue back to back.

Top module: `simd_alu`

## Requirements
- R1: Lane size code 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Opcode 0 adds lane by lane modulo the lane width, and no carry crosses into the next lane.
- R2: Opcode 1 subtracts B from A lane by lane modulo the lane width, and no borrow crosses a lane boundary.
- R3: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of the full 64-bit operands, whatever the lane size code.
- R4: Opcode 5 writes all ones into each lane where A equals B and all zeros elsewhere.
- R5: Opcode 6 writes all ones into each lane where A, read as a signed two's-complement lane, is greater than B, and all zeros elsewhere.
- R6: Opcode 7 shifts every lane left and opcode 8 shifts every lane right logically. The count is the whole 64-bit B operand read as unsigned and is shared by all lanes. Any count at or above the lane width gives zero.
- R7: Opcode 9 shifts every lane right arithmetically by the shared count in B. A count at or above the lane width fills the lane with its sign bit.
- R8: Opcode 10 reads the four 16-bit lanes of A and B as signed and multiplies matching lanes. It then adds products 0 and 1 into bits 31:0 and products 2 and 3 into bits 63:32, each sum wrapping modulo 2^32. The lane size code has no effect.
- R9: Opcode 11 copies operand B to the result. Opcodes 12 to 15 give a zero result.
- R10: Source A is register srcASel. Source B is immData when useImm is 1 and register srcBSel otherwise. All eight registers reset to zero.
- R11: After reset resValid and resData are 0. An operation issued with opValid at a clock edge appears on resData with resValid high after the next edge, and resValid is 1 only in that cycle. While resValid is low, resData holds its previous value.
- R12: Each result is written to register dstSel. An operation issued while resValid is high and naming that register reads the new result. Later operations read it from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue strobe for one operation |
| opCode | input | 4 | Operation select |
| elemSize | input | 2 | Lane size code |
| srcASel | input | 3 | Register index for source A |
| srcBSel | input | 3 | Register index for source B |
| useImm | input | 1 | Take source B from immData |
| immData | input | 64 | Immediate source B value |
| dstSel | input | 3 | Destination register index |
| resValid | output | 1 | Result valid pulse |
| resData | output | 64 | Registered result |

## Verification
The hardest case to reach from the ports is a carry, borrow or shift that would cross a lane boundary only under one size code, with the same bit pattern read under another size code. Only a few random values hit it. Directed steps therefore apply all-ones plus one and 0x8000 products under every size code. Shifts need counts exactly at, just below and far above each lane width, so shift operations draw most of their immediates from a small range around 0 to 80. Forwarding is covered by issuing dependent operations every cycle, so most reads land in the cycle the previous result is being written back.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_EQ   = 4'd5,
    OP_GT   = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_SRA  = 4'd9,
    OP_MADD = 4'd10,
    OP_MOVB = 4'd11
  } aluOp_e;

  // One-hot function strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic doAdd;
    logic doSub;
    logic doAnd;
    logic doOr;
    logic doXor;
    logic doEq;
    logic doGt;
    logic doShl;
    logic doShr;
    logic doSra;
    logic doMadd;
    logic doMov;
  } aluCtrl_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [SEL_W-1:0] dstSel,
  output aluCtrl_t         ctrl,
  output logic             resValid,
  output logic [SEL_W-1:0] wbDst
);

  always_comb begin
    ctrl = '0;
    ctrl.issue = opValid;
    case (opCode)
      OP_ADD:  ctrl.doAdd  = 1'b1;
      OP_SUB:  ctrl.doSub  = 1'b1;
      OP_AND:  ctrl.doAnd  = 1'b1;
      OP_OR:   ctrl.doOr   = 1'b1;
      OP_XOR:  ctrl.doXor  = 1'b1;
      OP_EQ:   ctrl.doEq   = 1'b1;
      OP_GT:   ctrl.doGt   = 1'b1;
      OP_SHL:  ctrl.doShl  = 1'b1;
      OP_SHR:  ctrl.doShr  = 1'b1;
      OP_SRA:  ctrl.doSra  = 1'b1;
      OP_MADD: ctrl.doMadd = 1'b1;
      OP_MOVB: ctrl.doMov  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      wbDst    <= '0;
    end else begin
      resValid <= opValid;
      if (opValid) wbDst <= dstSel;
    end
  end

endmodule

// File: rtl/simd_dpath.sv
module simd_dpath
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N),
  localparam int NSZ   = $clog2(DATA_W / 8) + 1,
  localparam int NPAIR = DATA_W / 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [1:0]        elemSize,
  input  logic [SEL_W-1:0]  srcASel,
  input  logic [SEL_W-1:0]  srcBSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] immData,
  input  logic              wbEn,
  input  logic [SEL_W-1:0]  wbDst,
  output logic [DATA_W-1:0] resData
);

  logic [DATA_W-1:0] rf [REG_N];
  logic [DATA_W-1:0] opA, opB;

  // Register read with bypass of the result being written back
  always_comb begin
    opA = rf[srcASel];
    if (wbEn && wbDst == srcASel) opA = resData;
    opB = rf[srcBSel];
    if (wbEn && wbDst == srcBSel) opB = resData;
    if (useImm) opB = immData;
  end

  // Per-size lane results; the size code picks one set
  logic [NSZ-1:0][DATA_W-1:0] addV, subV, eqV, gtV, shlV, shrV, sraV;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int W = 8 << s;
    localparam int N = DATA_W / W;
    logic       big;
    logic [5:0] amt;
    assign big = (opB > 64'(W - 1));
    assign amt = opB[5:0];
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [W-1:0] a, b;
      assign a = opA[l*W +: W];
      assign b = opB[l*W +: W];
      assign addV[s][l*W +: W] = a + b;
      assign subV[s][l*W +: W] = a - b;
      assign eqV[s][l*W +: W]  = {W{a == b}};
      assign gtV[s][l*W +: W]  = {W{$signed(a) > $signed(b)}};
      assign shlV[s][l*W +: W] = big ? '0 : a << amt;
      assign shrV[s][l*W +: W] = big ? '0 : a >> amt;
      assign sraV[s][l*W +: W] = big ? {W{a[W-1]}} : W'($signed(a) >>> amt);
    end
  end

  // Word multiply-add: adjacent signed products summed into dword lanes
  logic [DATA_W-1:0] maddV;
  for (genvar k = 0; k < NPAIR; k++) begin : g_madd
    logic signed [31:0] prodLo, prodHi;
    assign prodLo = $signed(opA[32*k +: 16])      * $signed(opB[32*k +: 16]);
    assign prodHi = $signed(opA[32*k + 16 +: 16]) * $signed(opB[32*k + 16 +: 16]);
    assign maddV[32*k +: 32] = prodLo + prodHi;
  end

  logic [DATA_W-1:0] nextRes;
  always_comb begin
    nextRes = ({DATA_W{ctrl.doAdd}}  & addV[elemSize])
            | ({DATA_W{ctrl.doSub}}  & subV[elemSize])
            | ({DATA_W{ctrl.doEq}}   & eqV[elemSize])
            | ({DATA_W{ctrl.doGt}}   & gtV[elemSize])
            | ({DATA_W{ctrl.doShl}}  & shlV[elemSize])
            | ({DATA_W{ctrl.doShr}}  & shrV[elemSize])
            | ({DATA_W{ctrl.doSra}}  & sraV[elemSize])
            | ({DATA_W{ctrl.doAnd}}  & (opA & opB))
            | ({DATA_W{ctrl.doOr}}   & (opA | opB))
            | ({DATA_W{ctrl.doXor}}  & (opA ^ opB))
            | ({DATA_W{ctrl.doMadd}} & maddV)
            | ({DATA_W{ctrl.doMov}}  & opB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      for (int i = 0; i < REG_N; i++) rf[i] <= '0;
    end else begin
      if (ctrl.issue) resData <= nextRes;
      if (wbEn) rf[wbDst] <= resData;
    end
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        elemSize,
  input  logic [SEL_W-1:0]  srcASel,
  input  logic [SEL_W-1:0]  srcBSel,
  input  logic              useImm,
  input  logic [DATA_W-1:0] immData,
  input  logic [SEL_W-1:0]  dstSel,
  output logic              resValid,
  output logic [DATA_W-1:0] resData
);

  aluCtrl_t         ctrl;
  logic [SEL_W-1:0] wbDst;

  simd_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .dstSel(dstSel), .ctrl(ctrl), .resValid(resValid), .wbDst(wbDst)
  );

  simd_dpath #(.DATA_W(DATA_W), .REG_N(REG_N)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .elemSize(elemSize),
    .srcASel(srcASel), .srcBSel(srcBSel), .useImm(useImm),
    .immData(immData), .wbEn(resValid), .wbDst(wbDst), .resData(resData)
  );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [SEL_W-1:0]  srcASel,
  input logic [SEL_W-1:0]  srcBSel,
  input logic              useImm,
  input logic [DATA_W-1:0] immData,
  input logic              resValid,
  input logic [DATA_W-1:0] resData
);

  function automatic logic bytesUniform(logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W / 8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  logic sameReg;
  assign sameReg = !useImm && (srcASel == srcBSel);

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (resValid == $past(opValid)));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !resValid) |-> $stable(resData));

  p_xor_self_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == OP_XOR && sameReg) |-> (resData == '0));

  p_sub_self_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == OP_SUB && sameReg) |-> (resData == '0));

  p_eq_self_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == OP_EQ && sameReg) |-> (resData == '1));

  p_cmp_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && (opCode == OP_EQ || opCode == OP_GT)) |-> bytesUniform(resData));

  p_shl_big_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(opValid && opCode == OP_SHL && useImm && immData >= 64) |-> (resData == '0));

endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .REG_N(REG_N)) u_chk (.*);

// File: tb/simd_alu_test.sv
`timescale 1ns/1ps
module simd_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  elemSize = '0;
  logic [2:0]  srcASel = '0, srcBSel = '0, dstSel = '0;
  logic        useImm = 1'b0;
  logic [63:0] immData = '0;
  logic        resValid;
  logic [63:0] resData;

  always #2 clk = ~clk;

  simd_alu uut (.*);

  int total = 0, bad = 0;
  logic [63:0] mregs [8];
  bit          pendValid = 0;
  logic [63:0] pendData = '0, lastData = '0;
  string       pendTag = "";

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string reqOf(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [3:0] op, logic [1:0] sz,
                                        logic [63:0] a, logic [63:0] b);
    int w = 8 << sz;
    int n = 64 / w;
    logic [63:0] m  = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] sb = 64'd1 << (w - 1);
    logic [63:0] r  = '0;
    case (op)
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd11: return b;
      4'd10: begin
        for (int k = 0; k < 2; k++) begin
          longint p0 = longint'($signed(a[32*k +: 16])) * longint'($signed(b[32*k +: 16]));
          longint p1 = longint'($signed(a[32*k+16 +: 16])) * longint'($signed(b[32*k+16 +: 16]));
          longint s = p0 + p1;
          r[32*k +: 32] = s[31:0];
        end
        return r;
      end
      4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
        for (int i = 0; i < n; i++) begin
          logic [63:0] ea = (a >> (i*w)) & m;
          logic [63:0] eb = (b >> (i*w)) & m;
          logic [63:0] v = '0;
          bit neg = (ea & sb) != 0;
          case (op)
            4'd0: v = (ea + eb) & m;
            4'd1: v = (ea - eb) & m;
            4'd5: v = (ea == eb) ? m : '0;
            4'd6: v = ((ea ^ sb) > (eb ^ sb)) ? m : '0;
            4'd7: v = (b >= 64'(w)) ? '0 : ((ea << b) & m);
            4'd8: v = (b >= 64'(w)) ? '0 : (ea >> b);
            default: v = (b >= 64'(w)) ? (neg ? m : '0)
                         : ((ea >> b) | (neg ? (m & ~(m >> b)) : '0));
          endcase
          r |= v << (i*w);
        end
        return r;
      end
      default: return '0;
    endcase
  endfunction

  // One cycle: check the previous cycle's issue, then drive the next
  task automatic step(bit v, logic [3:0] op, logic [1:0] sz, int a, int b,
                      bit imm, logic [63:0] iv, int d, string tag);
    chk({pendTag, " valid"}, 64'(resValid), 64'(pendValid));
    if (pendValid) begin
      chk(pendTag, resData, pendData);
      lastData = pendData;
    end else begin
      chk("R11 hold", resData, lastData);
    end
    opValid = v; opCode = op; elemSize = sz;
    srcASel = 3'(a); srcBSel = 3'(b); useImm = imm; immData = iv; dstSel = 3'(d);
    pendValid = v;
    if (v) begin
      logic [63:0] bv = imm ? iv : mregs[b];
      pendData = model(op, sz, mregs[a], bv);
      mregs[d] = pendData;
      pendTag = tag;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 4'd0, 2'd0, 0, 0, 0, '0, 0, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: got hang expected completion");
    bad++; total++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset valid", 64'(resValid), 64'd0);
    chk("R11 reset data", resData, 64'd0);
    // R10: registers reset to zero
    step(1, 4'd11, 2'd0, 0, 5, 0, '0, 6, "R10 reset reg");
    idle();
    // Load operands; srcBSel is ignored with the immediate (R10)
    step(1, 4'd11, 2'd0, 0, 7, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R10 imm");
    step(1, 4'd11, 2'd0, 0, 3, 1, 64'h0101_0101_0101_0101, 2, "R10 imm");
    step(1, 4'd11, 2'd0, 0, 0, 1, 64'h8000_8000_8000_8000, 3, "R10 imm");
    step(1, 4'd11, 2'd0, 0, 0, 1, 64'h8000_7FFF_0001_FF80, 4, "R10 imm");
    idle();
    // Lane carry/borrow isolation under each size (R1, R2)
    for (int s = 0; s < 4; s++) begin
      step(1, 4'd0, 2'(s), 1, 2, 0, '0, 5, "R1 lane carry");
      step(1, 4'd1, 2'(s), 0, 2, 0, '0, 5, "R2 lane borrow");
    end
    // Full-width logic ignores the size code (R3)
    step(1, 4'd4, 2'd0, 1, 4, 0, '0, 5, "R3 xor");
    step(1, 4'd2, 2'd3, 4, 3, 0, '0, 5, "R3 and");
    step(1, 4'd3, 2'd1, 2, 4, 0, '0, 5, "R3 or");
    // Compares (R4, R5)
    step(1, 4'd5, 2'd1, 3, 4, 0, '0, 5, "R4 eq");
    step(1, 4'd6, 2'd0, 4, 2, 0, '0, 5, "R5 gt signed");
    step(1, 4'd6, 2'd1, 3, 4, 0, '0, 5, "R5 gt signed");
    // Shift counts around each lane width (R6, R7)
    for (int s = 0; s < 4; s++) begin
      int w = 8 << s;
      step(1, 4'd7, 2'(s), 4, 0, 1, 64'(w - 1), 5, "R6 shl edge");
      step(1, 4'd7, 2'(s), 4, 0, 1, 64'(w), 5, "R6 shl big");
      step(1, 4'd8, 2'(s), 4, 0, 1, 64'(w - 1), 5, "R6 shr edge");
      step(1, 4'd9, 2'(s), 4, 0, 1, 64'(w - 1), 5, "R7 sra edge");
      step(1, 4'd9, 2'(s), 4, 0, 1, 64'd200, 5, "R7 sra big");
    end
    step(1, 4'd9, 2'd0, 4, 0, 1, 64'h1_0000_0001, 5, "R7 sra huge");
    // Multiply-add extremes (R8)
    step(1, 4'd10, 2'd0, 3, 3, 0, '0, 5, "R8 madd min");
    step(1, 4'd10, 2'd2, 4, 1, 0, '0, 5, "R8 madd");
    // Undefined opcode (R9)
    step(1, 4'd13, 2'd0, 1, 1, 0, '0, 6, "R9 undefined");
    // Back-to-back dependence through the bypass (R12)
    step(1, 4'd11, 2'd0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0, 7, "R12 load");
    step(1, 4'd0, 2'd2, 7, 7, 0, '0, 7, "R12 forward");
    step(1, 4'd1, 2'd1, 7, 1, 0, '0, 7, "R12 forward");
    idle();
    step(1, 4'd11, 2'd0, 0, 7, 0, '0, 0, "R12 readback");
    idle();
    idle();
    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom % 4) != 0;
      logic [3:0] op = ($urandom % 10 == 0) ? 4'($urandom) : 4'($urandom % 12);
      bit imm = $urandom % 2;
      logic [63:0] iv = {$urandom, $urandom};
      if (op >= 4'd7 && op <= 4'd9 && ($urandom % 4) != 0) iv = 64'($urandom % 80);
      step(v, op, 2'($urandom), int'($urandom % 8), int'($urandom % 8), imm, iv,
           int'($urandom % 8), reqOf(op));
    end
    idle();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule